// File: doc/BRIEF.md
# Status Queue with Destructive and Non-Destructive Read

This block is a small status queue that only the host reads. Logic on the device side pushes status words into it, one per cycle at most. The host reads the queue through two strobes. The pop strobe returns the head entry and removes it. The peek strobe returns the same head entry and leaves the queue as it was. Read data is registered and appears in the cycle after the strobe.

The block drives an entry count and empty/full flags. A runtime limit input caps the usable depth at any value up to the parameterised maximum. A push that finds no free slot is discarded, and a sticky overflow flag records the loss. The host has no write path into the queue.

Top module: `status_queue`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, overflow is 0 and rd_data is 0.
- R2: A push_valid cycle with a free slot appends push_data at the tail and raises count by one.
- R3: A pop_rd cycle on a non-empty queue puts the oldest entry on rd_data in the next cycle and removes it. Entries leave in the order they were pushed.
- R4: A peek_rd cycle on a non-empty queue puts the oldest entry on rd_data in the next cycle and leaves count and order unchanged. Repeated peeks return the same word.
- R5: A pop_rd or peek_rd on an empty queue gives rd_data 0 in the next cycle and removes nothing. A push in that same cycle is still accepted.
- R6: A push with no free slot is dropped and sets overflow. Overflow stays at 1 until reset.
- R7: Push and pop in the same cycle on a non-empty queue leave count unchanged and keep the order. On a full queue, the slot freed by the pop takes the push.
- R8: The effective limit is cfg_limit when it lies in 1..MAX_DEPTH, and MAX_DEPTH when it is 0 or larger. full is 1 when count is at or above the effective limit, and a push is accepted only while the count after any same-cycle pop is below the limit.
- R9: pop_rd and peek_rd in the same cycle act as a pop alone.
- R10: rd_data holds its value in any cycle with neither pop_rd nor peek_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Device-side push strobe |
| push_data | input | WIDTH | Status word to push |
| pop_rd | input | 1 | Host destructive read strobe |
| peek_rd | input | 1 | Host non-destructive read strobe |
| cfg_limit | input | CW | Runtime depth limit (0 means maximum) |
| rd_data | output | WIDTH | Registered read result |
| count | output | CW | Number of valid entries |
| empty | output | 1 | Queue holds no entries |
| full | output | 1 | Count at or above effective limit |
| overflow | output | 1 | Sticky flag for a dropped push |

## Verification
A device push and a host pop can land in the same cycle, and so can a pop and a peek. Random stimulus draws all three strobes independently each cycle, so these collisions occur often. Directed steps add a push+pop on a full queue, a push+pop on an empty queue, and a pop+peek. A bench queue model predicts the result of each collision: count unchanged and order kept for push+pop, and a single removal for pop+peek. The bench compares rd_data and count against the model one cycle after each step.

// File: rtl/status_queue.sv
module status_queue #(
  parameter int WIDTH     = 16,
  parameter int MAX_DEPTH = 8,
  localparam int AW = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
  localparam int CW = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_rd,
  input  logic             peek_rd,
  input  logic [CW-1:0]    cfg_limit,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             overflow
);

  logic [WIDTH-1:0] mem [MAX_DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q, lim;
  logic             do_pop, do_push, room;

  assign lim     = (cfg_limit == '0 || cfg_limit > CW'(MAX_DEPTH)) ? CW'(MAX_DEPTH) : cfg_limit;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q >= lim);
  assign count   = cnt_q;
  assign do_pop  = pop_rd && !empty;
  assign room    = ({1'b0, cnt_q} - {{CW{1'b0}}, do_pop}) < {1'b0, lim};
  assign do_push = push_valid && room;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(MAX_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt_q    <= '0;
      rd_data  <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (pop_rd || peek_rd) rd_data <= empty ? '0 : mem[rd_ptr];
      if (push_valid && !room) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/status_queue_chk.sv
module status_queue_chk #(
  parameter int WIDTH     = 16,
  parameter int MAX_DEPTH = 8,
  localparam int CW = $clog2(MAX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic [WIDTH-1:0] push_data,
  input logic             pop_rd,
  input logic             peek_rd,
  input logic [CW-1:0]    cfg_limit,
  input logic [WIDTH-1:0] rd_data,
  input logic [CW-1:0]    count,
  input logic             empty,
  input logic             full,
  input logic             overflow
);

  p_count_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(MAX_DEPTH));

  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_rd || peek_rd) && empty |=> rd_data == '0);

  p_peek_keeps_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    peek_rd && !pop_rd && !push_valid |=> $stable(count));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && full && !pop_rd |=> overflow && $stable(count));

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_pushpop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && pop_rd && !empty && !full |=> $stable(count));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_rd && !peek_rd |=> $stable(rd_data));

endmodule

bind status_queue status_queue_chk #(.WIDTH(WIDTH), .MAX_DEPTH(MAX_DEPTH)) u_chk (.*);

// File: tb/test_status_queue.sv
module test_status_queue;
  localparam int W  = 16;
  localparam int MD = 8;
  localparam int CW = $clog2(MD + 1);

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, pop_rd = 0, peek_rd = 0;
  logic [W-1:0] push_data = '0;
  logic [CW-1:0] cfg_limit = '0;
  logic [W-1:0] rd_data;
  logic [CW-1:0] count;
  logic empty, full, overflow;

  int checks = 0, errors = 0;
  logic [W-1:0] mq[$];
  logic [W-1:0] exp_rd = '0;
  bit exp_ovf = 0;

  always #4 clk = ~clk;

  status_queue #(.WIDTH(W), .MAX_DEPTH(MD)) i_status_queue (.*);

  function automatic int eff_lim(input logic [CW-1:0] l);
    return (l == 0 || l > MD) ? MD : int'(l);
  endfunction

  task automatic compare(input string tag);
    bit e_full = mq.size() >= eff_lim(cfg_limit);
    checks++;
    if (rd_data !== exp_rd || count !== CW'(mq.size()) || empty !== (mq.size() == 0) ||
        full !== e_full || overflow !== exp_ovf) begin
      errors++;
      $display("FAIL %s: rd=%h cnt=%0d emp=%b full=%b ovf=%b expected rd=%h cnt=%0d emp=%b full=%b ovf=%b",
               tag, rd_data, count, empty, full, overflow,
               exp_rd, mq.size(), mq.size() == 0, e_full, exp_ovf);
    end
  endtask

  task automatic step(input bit pu, input bit po, input bit pe, input logic [W-1:0] d, input string tag);
    bit was_empty, popped;
    @(negedge clk);
    push_valid = pu; pop_rd = po; peek_rd = pe; push_data = d;
    @(posedge clk);
    was_empty = (mq.size() == 0);
    if (po || pe) exp_rd = was_empty ? '0 : mq[0];
    popped = po && !was_empty;
    if (popped) void'(mq.pop_front());
    if (pu) begin
      if (mq.size() < eff_lim(cfg_limit)) mq.push_back(d);
      else exp_ovf = 1;
    end
    @(negedge clk);
    push_valid = 0; pop_rd = 0; peek_rd = 0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    mq.delete(); exp_rd = '0; exp_ovf = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk); compare("R1 reset state");
    step(0, 1, 0, 0, "R5 pop on empty");
    step(0, 0, 1, 0, "R5 peek on empty");
    step(1, 1, 0, 16'hA5A5, "R5 push with pop on empty");
    step(0, 0, 1, 0, "R4 peek head");
    step(0, 0, 1, 0, "R4 repeated peek");
    step(0, 0, 0, 0, "R10 hold with no read");
    for (int i = 0; i < 7; i++) step(1, 0, 0, W'(16'h1000 + i), "R2 fill");
    step(1, 0, 0, 16'hDEAD, "R6 push when full");
    step(0, 0, 0, 0, "R6 overflow sticky");
    step(1, 1, 0, 16'hBEEF, "R7 push and pop on full");
    step(0, 1, 1, 0, "R9 pop and peek together");
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, "R3 drain order");
    do_reset();
    cfg_limit = 3;
    for (int i = 0; i < 4; i++) step(1, 0, 0, W'(16'h2000 + i), "R8 limit 3");
    cfg_limit = 12;
    step(1, 0, 0, 16'h3000, "R8 limit above max");
    cfg_limit = 0;
    step(1, 0, 0, 16'h3001, "R8 limit zero means max");
    for (int i = 0; i < 3000; i++) begin
      bit pu = $urandom_range(0, 99) < 55;
      bit po = $urandom_range(0, 99) < 40;
      bit pe = $urandom_range(0, 99) < 20;
      string tag;
      if (i % 250 == 0) cfg_limit = CW'($urandom_range(0, 15));
      tag = (pu && po) ? "R7 random push+pop" : po ? "R3 random pop" : pe ? "R4 random peek" :
            pu ? "R2 random push" : "R10 random idle";
      step(pu, po, pe, W'($urandom), tag);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial void'($urandom(32'h5EED));
endmodule